// File: doc/BRIEF.md
# Multithreaded Fetch Thread Selector

This block decides, every cycle, which hardware thread is allowed to fetch. Each thread reports a small status code and an active bit. The selector grants one thread whose status allows fetching. It reports the thread's index and a valid flag. The grant is combinational from the present inputs and the stored priority order, so the fetch logic can use it in the same cycle.

Two modes are offered. In round-robin mode the selector keeps an ordered list of thread indices. It grants the first eligible thread found from the head of the list. On a strobed grant, only that thread is taken out and placed at the tail. In single-thread mode there is no list: the lowest-index active thread is granted if it may fetch. Enabling more than one thread in this mode is an illegal configuration, and the selector answers it with no grant.

Top module: `fetch_thread_pick`

## Requirements
- R1: A thread is eligible only when its active bit is set and its 3-bit status code is 0 (idle), 1 (running) or 2 (access complete); codes 3 to 7 are never eligible.
- R2: In round-robin mode the grant is the first eligible thread met when the list is scanned from the head, and the grant appears in the same cycle as the inputs.
- R3: On a committed rotation the granted thread moves to the tail, and the threads before and after it keep their relative order.
- R4: When no listed thread is eligible, gnt_vld is 0 and gnt_id is 0.
- R5: In single-thread mode with exactly one active bit set, that thread is granted if its status is eligible; otherwise there is no grant.
- R6: In single-thread mode with zero or more than one active bit set, there is no grant.
- R7: The list changes only at a clock edge where pick is 1, gnt_vld is 1 and single_mode is 0; at every other edge it holds.
- R8: Reset loads the list in ascending index order (thread 0 at the head), and the list always holds each thread index exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| thr_status | input | NTHR*STW | Status code of thread t in bits [t*STW +: STW] |
| act_mask | input | NTHR | Per-thread active bits |
| single_mode | input | 1 | 1 selects single-thread mode, 0 selects round-robin |
| pick | input | 1 | Strobe: commit the rotation for this cycle's grant |
| gnt_id | output | IW | Granted thread index (0 when no grant) |
| gnt_vld | output | 1 | A thread is granted this cycle |

## Verification
The grant and its valid flag are due in the same cycle as the statuses, mask and mode that cause them. The bench drives those inputs on the falling edge and compares the outputs 5 ns later, before the next rising edge. A rotation shows up only in the grant of the following cycle. The bench's own ordered list is therefore updated after the comparison, to mirror the rising edge that commits it. Directed phases cover reset order, pure rotation, hold without a strobe, eligibility codes, the single-thread cases and the empty case. A long pseudo-random round-robin phase then follows.

// File: rtl/fetch_thread_pick.sv
module fetch_thread_pick #(
  parameter int NTHR = 4,
  parameter int STW  = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NTHR*STW-1:0]  thr_status,
  input  logic [NTHR-1:0]      act_mask,
  input  logic                 single_mode,
  input  logic                 pick,
  output logic [(NTHR>1 ? $clog2(NTHR) : 1)-1:0] gnt_id,
  output logic                 gnt_vld
);
  localparam int IW = (NTHR > 1) ? $clog2(NTHR) : 1;
  localparam logic [STW-1:0] ST_IDLE = STW'(0);
  localparam logic [STW-1:0] ST_RUN  = STW'(1);
  localparam logic [STW-1:0] ST_DONE = STW'(2);

  logic [NTHR-1:0][IW-1:0] ord_q, ord_d;
  logic [NTHR-1:0] elig;
  logic            rr_hit, st_vld, one_act;
  logic [IW-1:0]   rr_id, hpos, first_act;

  for (genvar t = 0; t < NTHR; t++) begin : g_elig
    logic [STW-1:0] st;
    assign st = thr_status[t*STW +: STW];
    assign elig[t] = act_mask[t] && (st == ST_IDLE || st == ST_RUN || st == ST_DONE);
  end

  always_comb begin
    rr_hit = 1'b0;
    rr_id  = '0;
    hpos   = '0;
    for (int p = 0; p < NTHR; p++) begin
      if (!rr_hit && elig[ord_q[p]]) begin
        rr_hit = 1'b1;
        rr_id  = ord_q[p];
        hpos   = IW'(p);
      end
    end
  end

  always_comb begin
    first_act = '0;
    for (int t = NTHR - 1; t >= 0; t--)
      if (act_mask[t]) first_act = IW'(t);
  end

  assign one_act = ($countones(act_mask) == 1);
  assign st_vld  = one_act && elig[first_act];

  assign gnt_vld = single_mode ? st_vld : rr_hit;
  assign gnt_id  = !gnt_vld ? '0 : (single_mode ? first_act : rr_id);

  always_comb begin
    ord_d = ord_q;
    for (int p = 0; p < NTHR - 1; p++)
      if (p >= int'(hpos)) ord_d[p] = ord_q[p+1];
    ord_d[NTHR-1] = rr_id;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int p = 0; p < NTHR; p++) ord_q[p] <= IW'(p);
    end else if (pick && rr_hit && !single_mode) begin
      ord_q <= ord_d;
    end
  end
endmodule

module fetch_thread_pick_chk #(
  parameter int NTHR = 4,
  parameter int STW  = 3,
  parameter int IW   = 2
) (
  input logic                clk,
  input logic                rst_n,
  input logic [NTHR*STW-1:0] thr_status,
  input logic [NTHR-1:0]     act_mask,
  input logic                single_mode,
  input logic                pick,
  input logic [IW-1:0]       gnt_id,
  input logic                gnt_vld,
  input logic [NTHR*IW-1:0]  ord
);
  logic [NTHR-1:0] ok_t, seen;
  logic [IW-1:0]   head;
  logic            commit;

  for (genvar t = 0; t < NTHR; t++) begin : g_ok
    assign ok_t[t] = act_mask[t] && (thr_status[t*STW +: STW] < STW'(3));
  end

  always_comb begin
    seen = '0;
    for (int p = 0; p < NTHR; p++) seen[ord[p*IW +: IW]] = 1'b1;
  end

  assign head   = ord[IW-1:0];
  assign commit = pick && gnt_vld && !single_mode;

  p_elig_r1: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_vld |-> (act_mask[gnt_id] && thr_status[gnt_id*STW +: STW] < STW'(3)));
  p_head_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!single_mode && ok_t[head]) |-> (gnt_vld && gnt_id == head));
  p_tail_r3: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> (ord[(NTHR-1)*IW +: IW] == $past(gnt_id)));
  p_none_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ok_t == '0) |-> (!gnt_vld && gnt_id == '0));
  p_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (single_mode && $countones(act_mask) != 1) |-> !gnt_vld);
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(ord));
  p_perm_r8: assert property (@(posedge clk) disable iff (!rst_n)
    seen == {NTHR{1'b1}});
endmodule

bind fetch_thread_pick fetch_thread_pick_chk #(.NTHR(NTHR), .STW(STW), .IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .thr_status(thr_status), .act_mask(act_mask),
  .single_mode(single_mode), .pick(pick), .gnt_id(gnt_id), .gnt_vld(gnt_vld),
  .ord(ord_q)
);

// File: tb/sim_fetch_thread_pick.sv
module sim_fetch_thread_pick;
  localparam int NTHR = 4;
  localparam int STW  = 3;
  localparam int IW   = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NTHR*STW-1:0] thr_status = '0;
  logic [NTHR-1:0] act_mask = '0;
  logic single_mode = 1'b0;
  logic pick = 1'b0;
  logic [IW-1:0] gnt_id;
  logic gnt_vld;

  int checks = 0;
  int fails = 0;
  int mlist [NTHR];

  always #10 clk = ~clk;

  fetch_thread_pick #(.NTHR(NTHR), .STW(STW)) u0 (
    .clk(clk), .rst_n(rst_n), .thr_status(thr_status), .act_mask(act_mask),
    .single_mode(single_mode), .pick(pick), .gnt_id(gnt_id), .gnt_vld(gnt_vld)
  );

  function automatic bit m_elig(input logic [NTHR*STW-1:0] st,
                                input logic [NTHR-1:0] am, input int t);
    int code;
    code = int'(st[t*STW +: STW]);
    return am[t] && (code == 0 || code == 1 || code == 2);
  endfunction

  task automatic step(input logic [NTHR*STW-1:0] st, input logic [NTHR-1:0] am,
                      input logic sm, input logic pk, input string tag);
    bit ev;
    int eid, hp, cnt, fa;
    @(negedge clk);
    thr_status = st; act_mask = am; single_mode = sm; pick = pk;
    #5;
    ev = 0; eid = 0; hp = 0;
    if (sm) begin
      cnt = 0; fa = -1;
      for (int t = 0; t < NTHR; t++) if (am[t]) begin cnt++; if (fa < 0) fa = t; end
      if (cnt == 1 && m_elig(st, am, fa)) begin ev = 1; eid = fa; end
    end else begin
      for (int p = 0; p < NTHR; p++)
        if (!ev && m_elig(st, am, mlist[p])) begin ev = 1; eid = mlist[p]; hp = p; end
    end
    checks++;
    if (gnt_vld !== ev || int'(gnt_id) != eid) begin
      fails++;
      $display("FAIL %s: vld=%0b id=%0d expected vld=%0b id=%0d", tag, gnt_vld, gnt_id, ev, eid);
    end
    if (pk && ev && !sm) begin
      for (int p = hp; p < NTHR - 1; p++) mlist[p] = mlist[p+1];
      mlist[NTHR-1] = eid;
    end
  endtask

  function automatic logic [NTHR*STW-1:0] fill(input int code);
    logic [NTHR*STW-1:0] v;
    for (int t = 0; t < NTHR; t++) v[t*STW +: STW] = STW'(code);
    return v;
  endfunction

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [NTHR*STW-1:0] st;
    for (int p = 0; p < NTHR; p++) mlist[p] = p;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R8: ascending order after reset
    step(fill(1), 4'hF, 1'b0, 1'b0, "R8");
    // R3: full rotation with all eligible, then with thread 1 blocked
    for (int i = 0; i < 6; i++) step(fill(1), 4'hF, 1'b0, 1'b1, "R3");
    st = fill(0); st[1*STW +: STW] = 3'd4;
    for (int i = 0; i < 6; i++) step(st, 4'hF, 1'b0, 1'b1, "R3");
    // R7: no strobe, or single mode with strobe, must not rotate
    for (int i = 0; i < 4; i++) step(fill(2), 4'hF, 1'b0, 1'b0, "R7");
    for (int i = 0; i < 4; i++) step(fill(1), 4'h4, 1'b1, 1'b1, "R7");
    for (int i = 0; i < 3; i++) step(fill(1), 4'hF, 1'b0, 1'b0, "R7");
    // R1: every code on every thread, others ineligible; also inactive thread
    for (int t = 0; t < NTHR; t++)
      for (int c = 0; c < 8; c++) begin
        st = fill(7); st[t*STW +: STW] = STW'(c);
        step(st, 4'hF, 1'b0, 1'b0, "R1");
        step(st, 4'hF & ~(4'h1 << t), 1'b0, 1'b0, "R1");
      end
    // R4: nothing eligible, with and without strobe
    for (int c = 3; c < 8; c++) step(fill(c), 4'hF, 1'b0, 1'b1, "R4");
    step(fill(1), 4'h0, 1'b0, 1'b1, "R4");
    // R5: single mode, one active thread, every code
    for (int t = 0; t < NTHR; t++)
      for (int c = 0; c < 8; c++) begin
        st = fill(5); st[t*STW +: STW] = STW'(c);
        step(st, 4'h1 << t, 1'b1, 1'b1, "R5");
      end
    // R6: single mode with zero or several active threads
    for (int m = 0; m < 16; m++)
      if ($countones(m) != 1) step(fill(1), 4'(m), 1'b1, 1'b1, "R6");
    // R2: pseudo-random round-robin traffic
    for (int i = 0; i < 3000; i++) begin
      for (int t = 0; t < NTHR; t++) st[t*STW +: STW] = STW'($urandom_range(0, 4));
      step(st, 4'($urandom_range(0, 15)), 1'b0, 1'($urandom_range(0, 3) != 0), "R2");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule